// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a bank of 8-bit configuration registers that a host reaches through a window of two adjacent I/O byte addresses. A write to the even address of the window stores a pointer (the index). Any access to the odd address reaches the register that the index selects. A read at either address returns that register. The window exists only while one enable bit of an external bridge configuration byte is set. While the bit is clear, reads return all ones, no acknowledge is given, and writes are dropped.

Only some indices can be written. Everything below 0xE0 is read-only, and a scattered set of indices above 0xE0 is read-only as well. Indices that cannot be written always read as 0x00. Six registers have fixed non-zero values at reset. Two of those registers hold base settings for the serial ports. Each of the two accepts exactly one supported value. A write of any other value to either one is still stored, but the block raises a one-cycle flag so that the surrounding logic can note an unsupported configuration.

Top module: `sio_cfg_port`

## Requirements
- R1: A write strobe at the window's even address (default 0x3F0) loads the 8-bit index from the write data. A write strobe at the odd address (0x3F1) writes the register selected by the current index.
- R2: A read strobe at either window address sets `io_rd_ack` high in the next cycle, with `io_rdata` holding the byte at the current index. `io_rd_ack` is low in every cycle that does not follow such a read.
- R3: Data writes take effect only at indices 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC. At every other index the write is ignored and the register reads 0x00.
- R4: After reset: index 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 reads 0xFE and 0xE8 reads 0xBE. All other registers read 0x00, the index is 0x00, `io_rdata` is 0xFF, and `io_rd_ack` and `unsup_pulse` are low.
- R5: A data write to index 0xE7 with a value other than 0xFE, or to index 0xE8 with a value other than 0xBE, raises `unsup_pulse` for exactly the cycle after the write strobe, and the value is still stored. Writing 0xFE to 0xE7, writing 0xBE to 0xE8, and writing to any other index never raise it.
- R6: The window responds only while bit 1 of `bridge_cfg` is 1. While that bit is 0, a read gives `io_rdata` = 0xFF with no ack in the next cycle, and writes change neither the index nor any register and raise no flag.
- R7: An access to an address outside the two-byte window is ignored in the same way as an access to a disabled window: 0xFF, no ack, no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_cfg | input | 8 | Bridge configuration byte; bit 1 enables the window |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data, 0xFF when no read hit |
| io_rd_ack | output | 1 | High in the cycle after a read that hit the window |
| unsup_pulse | output | 1 | One-cycle flag for an unsupported serial base value |

## Verification
Every register value, including the stored index, reaches the ports through a data-port read exactly one cycle after the strobe. A corrupted index, a wrong protection bit or a wrong reset value therefore shows as a wrong `io_rdata` on the first read that follows. A protected index that wrongly accepts a write is seen by reading back that same index right after the write. A faulty guard comparison shows on `unsup_pulse` in the cycle right after the write. An enable decode that leaks shows at once as a non-0xFF read, or later as a register that changed when it should have kept its value.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int IDX_W = 8;

  typedef struct packed {
    logic idx_wr;
    logic dat_wr;
    logic rd_hit;
  } sio_strobe_t;

  // Indices at or above 0xE0 that accept data writes.
  function automatic logic idx_writable(input logic [IDX_W-1:0] i);
    if (i < 8'hE0) return 1'b0;
    case (i)
      8'hE4, 8'hE5,
      8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
      8'hF3, 8'hF5, 8'hF7,
      8'hF9, 8'hFA, 8'hFB,
      8'hFD, 8'hFE, 8'hFF: return 1'b0;
      default:            return 1'b1;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] idx_reset(input logic [IDX_W-1:0] i);
    case (i)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_io_decode.sv
module sio_io_decode
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     WIN_BASE = 16'h03F0,
  parameter int              EN_BIT   = 1
) (
  input  logic [7:0]        cfg_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output sio_strobe_t       stb
);
  localparam logic [ADDR_W-1:0] BASE = WIN_BASE[ADDR_W-1:0];

  logic in_win;
  logic win_on;

  always_comb begin
    win_on     = cfg_byte[EN_BIT];
    in_win     = win_on && (addr[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
    stb.idx_wr = in_win && wr && !addr[0];
    stb.dat_wr = in_win && wr && addr[0];
    stb.rd_hit = in_win && rd;
  end
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] BANK_BASE = 8'hE0,
  parameter int         BANK_N    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] rd_byte
);
  localparam int BANK_AW = (BANK_N > 1) ? $clog2(BANK_N) : 1;

  logic [IDX_W-1:0] cell_q [BANK_N];
  logic             in_bank;
  logic [BANK_AW-1:0] off;

  always_comb begin
    in_bank = (int'(idx) >= int'(BANK_BASE)) &&
              (int'(idx) <  int'(BANK_BASE) + BANK_N);
    off     = BANK_AW'(idx - BANK_BASE);
  end

  for (genvar g = 0; g < BANK_N; g++) begin : g_cell
    localparam logic [IDX_W-1:0] CELL_IDX = BANK_BASE + IDX_W'(g);
    if (idx_writable(CELL_IDX)) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)
          cell_q[g] <= idx_reset(CELL_IDX);
        else if (wr_en && in_bank && off == BANK_AW'(g))
          cell_q[g] <= wdata;
      end
    end else begin : g_ro
      assign cell_q[g] = '0;
    end
  end

  always_comb rd_byte = in_bank ? cell_q[off] : '0;
endmodule

// File: rtl/sio_guard_check.sv
module sio_guard_check
  import sio_cfg_pkg::*;
#(
  parameter int               N_GUARD  = 2,
  parameter logic [15:0]      GUARD_IDX [N_GUARD] = '{16'h00E7, 16'h00E8},
  parameter logic [15:0]      GUARD_OK  [N_GUARD] = '{16'h00FE, 16'h00BE}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] wdata,
  output logic             flag
);
  logic [N_GUARD-1:0] miss;

  for (genvar g = 0; g < N_GUARD; g++) begin : g_cmp
    assign miss[g] = (idx == GUARD_IDX[g][IDX_W-1:0]) &&
                     (wdata != GUARD_OK[g][IDX_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= wr_en && (|miss);
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] WIN_BASE  = 16'h03F0,
  parameter int          EN_BIT    = 1,
  parameter logic [7:0]  BANK_BASE = 8'hE0,
  parameter int          BANK_N    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bridge_cfg,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic              io_rd_ack,
  output logic              unsup_pulse
);
  sio_strobe_t      stb;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] bank_rd;

  sio_io_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .EN_BIT(EN_BIT)
  ) u_dec (
    .cfg_byte(bridge_cfg), .addr(io_addr), .rd(io_rd), .wr(io_wr), .stb(stb)
  );

  always_ff @(posedge clk) begin
    if (rst)             idx_q <= '0;
    else if (stb.idx_wr) idx_q <= io_wdata;
  end

  sio_reg_bank #(
    .BANK_BASE(BANK_BASE), .BANK_N(BANK_N)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(stb.dat_wr), .idx(idx_q),
    .wdata(io_wdata), .rd_byte(bank_rd)
  );

  sio_guard_check u_guard (
    .clk(clk), .rst(rst), .wr_en(stb.dat_wr), .idx(idx_q),
    .wdata(io_wdata), .flag(unsup_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= 8'hFF;
      io_rd_ack <= 1'b0;
    end else begin
      io_rd_ack <= stb.rd_hit;
      io_rdata  <= stb.rd_hit ? bank_rd : 8'hFF;
    end
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'h03F0,
  parameter int          EN_BIT   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        bridge_cfg,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              io_rd_ack,
  input logic              unsup_pulse
);
  logic hit_addr;
  assign hit_addr = (io_addr[ADDR_W-1:1] == WIN_BASE[ADDR_W-1:1]);

  // R2: an enabled read in the window is acknowledged next cycle
  a_r2_read_ack: assert property (@(posedge clk) disable iff (rst)
    (io_rd && bridge_cfg[EN_BIT] && hit_addr) |=> io_rd_ack);

  // R2: no ack without a read strobe in the previous cycle
  a_r2_ack_has_cause: assert property (@(posedge clk) disable iff (rst)
    io_rd_ack |-> $past(io_rd));

  // R5: flag only follows a write strobe
  a_r5_flag_after_write: assert property (@(posedge clk) disable iff (rst)
    unsup_pulse |-> $past(io_wr));

  // R6: disabled window never acknowledges and returns all ones
  a_r6_disabled_read: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !bridge_cfg[EN_BIT]) |=> (!io_rd_ack && io_rdata == 8'hFF));

  // R6: writes to a disabled window raise no flag
  a_r6_disabled_write: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !bridge_cfg[EN_BIT]) |=> !unsup_pulse);

  // R7: reads outside the window are not acknowledged
  a_r7_outside_read: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !hit_addr) |=> (!io_rd_ack && io_rdata == 8'hFF));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .bridge_cfg(bridge_cfg), .io_addr(io_addr),
  .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
  .io_rd_ack(io_rd_ack), .unsup_pulse(unsup_pulse)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bridge_cfg = 8'h02;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_rd_ack;
  logic        unsup_pulse;

  localparam logic [15:0] A_IDX = 16'h03F0;
  localparam logic [15:0] A_DAT = 16'h03F1;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst(rst), .bridge_cfg(bridge_cfg), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .io_rd_ack(io_rd_ack), .unsup_pulse(unsup_pulse)
  );

  typedef struct {
    logic [7:0] data;
    logic       ack;
    string      tag;
  } exp_t;

  exp_t exp_q [$];
  int   n_chk  = 0;
  int   n_fail = 0;
  logic rd_seen = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: compares one cycle after each read strobe.
  always @(posedge clk) rd_seen <= io_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 actual=unexpected read expected=none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " ack"},  {7'b0, io_rd_ack}, {7'b0, e.ack});
        check({e.tag, " data"}, io_rdata, e.data);
      end
    end else if (!rst) begin
      if (io_rd_ack) begin
        n_chk++; n_fail++;
        $display("FAIL R2 actual=ack expected=no ack");
      end
    end
  end

  task automatic do_read(input logic [15:0] a, input logic [7:0] d,
                         input logic ack, input string tag);
    exp_t e;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    e.data = d; e.ack = ack; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          input logic pulse, input string tag);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    check({tag, " pulse"}, {7'b0, unsup_pulse}, {7'b0, pulse});
  endtask

  task automatic set_idx(input logic [7:0] i);
    do_write(A_IDX, i, 1'b0, "R1");
  endtask

  task automatic rd_idx(input logic [7:0] i, input logic [7:0] d, input string tag);
    set_idx(i);
    do_read(A_DAT, d, 1'b1, tag);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset outputs
    check("R4 rdata reset", io_rdata, 8'hFF);
    check("R4 ack reset", {7'b0, io_rd_ack}, 8'h00);
    check("R4 pulse reset", {7'b0, unsup_pulse}, 8'h00);
    rst = 1'b0;

    // R4: index resets to 0, register 0 reads 0
    do_read(A_DAT, 8'h00, 1'b1, "R4 idx0");
    rd_idx(8'hE0, 8'h3C, "R4 E0");
    rd_idx(8'hE2, 8'h03, "R4 E2");
    rd_idx(8'hE3, 8'hFC, "R4 E3");
    rd_idx(8'hE6, 8'hDE, "R4 E6");
    rd_idx(8'hE7, 8'hFE, "R4 E7");
    rd_idx(8'hE8, 8'hBE, "R4 E8");
    rd_idx(8'hE1, 8'h00, "R4 E1");
    // R2: read at index address returns the selected register
    do_read(A_IDX, 8'h00, 1'b1, "R2 even addr");

    // R1/R3: writable indices
    set_idx(8'hE1); do_write(A_DAT, 8'h5A, 1'b0, "R3 E1");
    do_read(A_DAT, 8'h5A, 1'b1, "R1 E1 readback");
    rd_idx(8'hE1, 8'h5A, "R3 E1");
    set_idx(8'hF4); do_write(A_DAT, 8'h11, 1'b0, "R3 F4");
    do_read(A_DAT, 8'h11, 1'b1, "R3 F4");
    set_idx(8'hFC); do_write(A_DAT, 8'h77, 1'b0, "R3 FC");
    do_read(A_DAT, 8'h77, 1'b1, "R3 FC");
    set_idx(8'hE0); do_write(A_DAT, 8'hFE, 1'b0, "R5 E0 no flag");
    do_read(A_DAT, 8'hFE, 1'b1, "R3 E0");

    // R3: protected indices
    set_idx(8'hE4); do_write(A_DAT, 8'hAA, 1'b0, "R3 E4");
    do_read(A_DAT, 8'h00, 1'b1, "R3 E4 protected");
    set_idx(8'h10); do_write(A_DAT, 8'h55, 1'b0, "R3 10");
    do_read(A_DAT, 8'h00, 1'b1, "R3 10 protected");
    set_idx(8'hFD); do_write(A_DAT, 8'h99, 1'b0, "R3 FD");
    do_read(A_DAT, 8'h00, 1'b1, "R3 FD protected");
    set_idx(8'hEB); do_write(A_DAT, 8'h3C, 1'b0, "R3 EB");
    do_read(A_DAT, 8'h00, 1'b1, "R3 EB protected");

    // R5: guarded serial base indices
    set_idx(8'hE7); do_write(A_DAT, 8'h12, 1'b1, "R5 E7 bad");
    do_read(A_DAT, 8'h12, 1'b1, "R5 E7 stored");
    do_write(A_DAT, 8'hFE, 1'b0, "R5 E7 ok");
    set_idx(8'hE8); do_write(A_DAT, 8'hBE, 1'b0, "R5 E8 ok");
    do_write(A_DAT, 8'h00, 1'b1, "R5 E8 bad");
    do_read(A_DAT, 8'h00, 1'b1, "R5 E8 stored");

    // R6: disabled window
    set_idx(8'hE1);
    bridge_cfg = 8'hFD;
    do_read(A_DAT, 8'hFF, 1'b0, "R6 read disabled");
    do_write(A_DAT, 8'h00, 1'b0, "R6 data write disabled");
    do_write(A_IDX, 8'hE7, 1'b0, "R6 idx write disabled");
    do_write(A_DAT, 8'h01, 1'b0, "R6 guarded write disabled");
    bridge_cfg = 8'h02;
    do_read(A_DAT, 8'h5A, 1'b1, "R6 state kept");
    rd_idx(8'hE7, 8'hFE, "R6 E7 kept");

    // R7: outside the window
    set_idx(8'hE1);
    do_write(16'h03F2, 8'hE3, 1'b0, "R7 write outside");
    do_write(16'h02F1, 8'h33, 1'b0, "R7 write alias");
    do_read(16'h03F3, 8'hFF, 1'b0, "R7 read outside");
    do_read(A_DAT, 8'h5A, 1'b1, "R7 state kept");

    // R4: reset mid-run restores values
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_read(A_DAT, 8'h00, 1'b1, "R4 idx after reset");
    rd_idx(8'hE1, 8'h00, "R4 E1 after reset");
    rd_idx(8'hE7, 8'hFE, "R4 E7 after reset");
    rd_idx(8'hE0, 8'h3C, "R4 E0 after reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule